// File: doc/BRIEF.md
# Credit-Linked Decoupling Queue With Flush

This block splits one pipeline into two synchronous halves joined by a small in-order queue. The frontend half pushes entries, each a data payload plus a sequence tag, and may push only while it holds a credit. The block keeps the frontend credit count. The backend half sees the oldest entry at its head and pops it. Every pop returns one credit on a dedicated return port. The credit count then rises on the next clock edge.

Kills cross the queue in both directions. A kill-younger raised by the backend empties the queue. It returns every credit and sends a one-cycle flush pulse back to the frontend. A kill-younger raised by the frontend, after its queue-write stage, names a boundary tag. Every queued entry whose tag is younger than the boundary is discarded, and the write pointer moves back to sit just after the youngest survivor. Ages are compared modulo the tag width, so the comparison still works when the tags wrap. The pipelines themselves are outside the block and appear only as handshake ports.

Top module: `cdq_link_queue`

## Requirements
- R1: After synchronous reset, `fe_credits` equals DEPTH (8), `fe_ready` is 1, `be_valid` is 0, `fe_flush` is 0 and `crd_ret` is 0.
- R2: When `fe_valid` is 1, a credit is held and no kill is raised, the entry is queued and `fe_credits` drops by one at the next edge. Entries reach `be_data`/`be_tag` in the order they were written.
- R3: A write presented while `fe_credits` is 0 is dropped. Neither the credit count nor the queue contents change.
- R4: A pop while `be_valid` is 1 and no kill is raised removes the head. It drives `crd_ret` to 1 in the same cycle, and `fe_credits` rises by one at the next edge. A pop while the queue is empty does nothing.
- R5: When `be_kill` is 1, `crd_ret` equals the current occupancy in that cycle. At the next edge the queue is empty, `fe_credits` equals DEPTH and `fe_flush` is 1 for one cycle.
- R6: When `fe_kill` is 1, every queued entry whose tag is younger than `fe_kill_tag` is discarded. An entry's tag is younger when (tag - fe_kill_tag) mod 2^TAG_W is nonzero and has its top bit clear. Older entries and an entry with an equal tag remain, in their order. `crd_ret` counts the discarded entries in the same cycle, and `fe_credits` takes them back at the next edge.
- R7: After a frontend trim, the next write lands directly behind the youngest surviving entry, because the write pointer is restored.
- R8: The age comparison of R6 works across tag wraparound. For example, with boundary 31, tags 0 and 1 are younger and tag 30 is older.
- R9: If `be_kill` and `fe_kill` are raised in the same cycle, the backend flush wins and the queue is emptied completely.
- R10: During any kill cycle a frontend write is ignored. During a frontend trim, a pop is honoured only if the head entry survives the trim, and that pop adds one to `crd_ret`.
- R11: `fe_credits` plus the queue occupancy always equals DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fe_valid | input | 1 | Frontend presents an entry |
| fe_data | input | DATA_W | Entry payload |
| fe_tag | input | TAG_W | Entry sequence tag |
| fe_ready | output | 1 | At least one credit is held |
| fe_credits | output | $clog2(DEPTH)+1 | Credits held by the frontend |
| fe_kill | input | 1 | Frontend kill-younger, trims by tag |
| fe_kill_tag | input | TAG_W | Tag of the killing frontend transaction |
| fe_flush | output | 1 | Flush pulse to the frontend after a backend kill |
| be_valid | output | 1 | Queue holds at least one entry |
| be_data | output | DATA_W | Head entry payload |
| be_tag | output | TAG_W | Head entry tag |
| be_pop | input | 1 | Backend consumes the head entry |
| be_kill | input | 1 | Backend kill-younger, empties the queue |
| crd_ret | output | $clog2(DEPTH)+1 | Credits returned this cycle |

## Verification
`crd_ret` is combinational from the inputs and the current state. The bench therefore reads it one time unit after driving the inputs on the falling edge, before the rising edge that acts on them. `fe_credits`, `be_valid`, `be_data`, `be_tag` and `fe_flush` reflect a stimulus one rising edge later. They are checked at the following falling edge, before the next stimulus is driven. Trims, flushes and same-cycle kill collisions are confirmed by draining the queue through the backend port, which exposes the surviving order and the restored write position.

// File: rtl/cdq_pkg.sv
package cdq_pkg;

    // Which of the three mutually exclusive update paths acts this cycle.
    typedef enum logic [1:0] {
        OP_RUN   = 2'd0,
        OP_TRIM  = 2'd1,
        OP_FLUSH = 2'd2
    } cdq_op_e;

    // Per-cycle control bundle handed to the storage.
    typedef struct packed {
        cdq_op_e op;
        logic    wr_req;
        logic    pop_req;
    } cdq_ctrl_t;

    // A backend flush outranks a frontend trim.
    function automatic cdq_op_e pick_op(input logic back_kill, input logic front_kill);
        if (back_kill)
            return OP_FLUSH;
        else if (front_kill)
            return OP_TRIM;
        else
            return OP_RUN;
    endfunction

endpackage

// File: rtl/cdq_credit.sv
module cdq_credit #(
    parameter int DEPTH = 8,
    localparam int CW = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          take,
    input  logic [CW-1:0] give_back,
    output logic [CW-1:0] credits,
    output logic          has_credit
);
    always_ff @(posedge clk) begin
        if (rst)
            credits <= CW'(DEPTH);
        else
            credits <= credits - CW'(take) + give_back;
    end

    assign has_credit = (credits != '0);
endmodule

// File: rtl/cdq_flush_link.sv
module cdq_flush_link (
    input  logic clk,
    input  logic rst,
    input  logic back_kill,
    output logic front_flush
);
    always_ff @(posedge clk) begin
        if (rst)
            front_flush <= 1'b0;
        else
            front_flush <= back_kill;
    end
endmodule

// File: rtl/cdq_store.sv
module cdq_store
    import cdq_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int TAG_W  = 5,
    parameter int DEPTH  = 8,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = AW + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  cdq_ctrl_t         ctrl,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [TAG_W-1:0]  kill_tag,
    output logic [DATA_W-1:0] head_data,
    output logic [TAG_W-1:0]  head_tag,
    output logic [CW-1:0]     count,
    output logic [CW-1:0]     ret_cnt,
    output logic              wr_done
);
    function automatic logic tag_younger(input logic [TAG_W-1:0] t,
                                         input logic [TAG_W-1:0] k);
        logic [TAG_W-1:0] d;
        d = t - k;
        return (d != '0) && !d[TAG_W-1];
    endfunction

    logic [DATA_W-1:0] mem_data [DEPTH];
    logic [TAG_W-1:0]  mem_tag  [DEPTH];
    logic [AW-1:0]     rptr, wptr;
    logic [AW-1:0]     rptr_n, wptr_n;
    logic [CW-1:0]     count_n;
    logic [DEPTH-1:0]  occ, young;
    logic [AW-1:0]     slot_off [DEPTH];
    logic [CW-1:0]     keep;
    logic              pop_ok;

    // Slot classification: occupied, and younger than the kill boundary.
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        assign slot_off[g] = AW'(g) - rptr;
        assign occ[g]      = ({1'b0, slot_off[g]} < count);
        assign young[g]    = occ[g] && tag_younger(mem_tag[g], kill_tag);
    end

    assign keep = CW'($countones(occ & ~young));

    always_comb begin
        rptr_n  = rptr;
        wptr_n  = wptr;
        count_n = count;
        ret_cnt = '0;
        pop_ok  = 1'b0;
        wr_done = 1'b0;
        unique case (ctrl.op)
            OP_FLUSH: begin
                ret_cnt = count;
                count_n = '0;
                wptr_n  = rptr;
            end
            OP_TRIM: begin
                pop_ok  = ctrl.pop_req && (count != '0) && !young[rptr];
                ret_cnt = count - keep + CW'(pop_ok);
                count_n = keep - CW'(pop_ok);
                rptr_n  = rptr + AW'(pop_ok);
                wptr_n  = rptr + keep[AW-1:0];
            end
            default: begin
                pop_ok  = ctrl.pop_req && (count != '0);
                wr_done = ctrl.wr_req;
                ret_cnt = CW'(pop_ok);
                count_n = count + CW'(wr_done) - CW'(pop_ok);
                rptr_n  = rptr + AW'(pop_ok);
                wptr_n  = wptr + AW'(wr_done);
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rptr  <= '0;
            wptr  <= '0;
            count <= '0;
        end else begin
            rptr  <= rptr_n;
            wptr  <= wptr_n;
            count <= count_n;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_done) begin
            mem_data[wptr] <= wr_data;
            mem_tag[wptr]  <= wr_tag;
        end
    end

    assign head_data = mem_data[rptr];
    assign head_tag  = mem_tag[rptr];
endmodule

// File: rtl/cdq_link_queue.sv
module cdq_link_queue
    import cdq_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int TAG_W  = 5,
    parameter int DEPTH  = 8,
    localparam int CW = $clog2(DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fe_valid,
    input  logic [DATA_W-1:0] fe_data,
    input  logic [TAG_W-1:0]  fe_tag,
    output logic              fe_ready,
    output logic [CW-1:0]     fe_credits,
    input  logic              fe_kill,
    input  logic [TAG_W-1:0]  fe_kill_tag,
    output logic              fe_flush,
    output logic              be_valid,
    output logic [DATA_W-1:0] be_data,
    output logic [TAG_W-1:0]  be_tag,
    input  logic              be_pop,
    input  logic              be_kill,
    output logic [CW-1:0]     crd_ret
);
    cdq_ctrl_t     ctrl;
    logic [CW-1:0] occ_count;
    logic          wr_done;

    always_comb begin
        ctrl.op      = pick_op(be_kill, fe_kill);
        ctrl.wr_req  = fe_valid && fe_ready;
        ctrl.pop_req = be_pop;
    end

    cdq_store #(.DATA_W(DATA_W), .TAG_W(TAG_W), .DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst       (rst),
        .ctrl      (ctrl),
        .wr_data   (fe_data),
        .wr_tag    (fe_tag),
        .kill_tag  (fe_kill_tag),
        .head_data (be_data),
        .head_tag  (be_tag),
        .count     (occ_count),
        .ret_cnt   (crd_ret),
        .wr_done   (wr_done)
    );

    cdq_credit #(.DEPTH(DEPTH)) u_credit (
        .clk        (clk),
        .rst        (rst),
        .take       (wr_done),
        .give_back  (crd_ret),
        .credits    (fe_credits),
        .has_credit (fe_ready)
    );

    cdq_flush_link u_flush (
        .clk         (clk),
        .rst         (rst),
        .back_kill   (be_kill),
        .front_flush (fe_flush)
    );

    assign be_valid = (occ_count != '0);
endmodule

// File: rtl/cdq_link_queue_chk.sv
module cdq_link_queue_chk #(
    parameter int DEPTH = 8,
    localparam int CW = $clog2(DEPTH) + 1
) (
    input logic          clk,
    input logic          rst,
    input logic          fe_valid,
    input logic          fe_ready,
    input logic [CW-1:0] fe_credits,
    input logic          fe_kill,
    input logic          fe_flush,
    input logic          be_valid,
    input logic          be_pop,
    input logic          be_kill,
    input logic [CW-1:0] crd_ret,
    input logic [CW-1:0] occ_count
);
    assert_credit_sum_R11: assert property (@(posedge clk) disable iff (rst)
        (int'(fe_credits) + int'(occ_count)) == DEPTH);

    assert_flush_empties_R5: assert property (@(posedge clk) disable iff (rst)
        be_kill |=> (!be_valid && (int'(fe_credits) == DEPTH) && fe_flush));

    assert_flush_origin_R5: assert property (@(posedge clk) disable iff (rst)
        fe_flush |-> $past(be_kill));

    assert_no_write_without_credit_R3: assert property (@(posedge clk) disable iff (rst)
        (fe_valid && !fe_ready && !be_pop && !be_kill && !fe_kill) |=> $stable(fe_credits));

    assert_pop_returns_one_R4: assert property (@(posedge clk) disable iff (rst)
        (be_pop && be_valid && !be_kill && !fe_kill) |-> (crd_ret == CW'(1)));
endmodule

bind cdq_link_queue cdq_link_queue_chk #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .fe_valid   (fe_valid),
    .fe_ready   (fe_ready),
    .fe_credits (fe_credits),
    .fe_kill    (fe_kill),
    .fe_flush   (fe_flush),
    .be_valid   (be_valid),
    .be_pop     (be_pop),
    .be_kill    (be_kill),
    .crd_ret    (crd_ret),
    .occ_count  (occ_count)
);

// File: tb/cdq_link_queue_tb.sv
module cdq_link_queue_tb;
    localparam int DW = 16;
    localparam int TW = 5;
    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          fe_valid = 1'b0;
    logic [DW-1:0] fe_data = '0;
    logic [TW-1:0] fe_tag = '0;
    logic          fe_ready;
    logic [CW-1:0] fe_credits;
    logic          fe_kill = 1'b0;
    logic [TW-1:0] fe_kill_tag = '0;
    logic          fe_flush;
    logic          be_valid;
    logic [DW-1:0] be_data;
    logic [TW-1:0] be_tag;
    logic          be_pop = 1'b0;
    logic          be_kill = 1'b0;
    logic [CW-1:0] crd_ret;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    cdq_link_queue u_dut (
        .clk(clk), .rst(rst),
        .fe_valid(fe_valid), .fe_data(fe_data), .fe_tag(fe_tag),
        .fe_ready(fe_ready), .fe_credits(fe_credits),
        .fe_kill(fe_kill), .fe_kill_tag(fe_kill_tag), .fe_flush(fe_flush),
        .be_valid(be_valid), .be_data(be_data), .be_tag(be_tag),
        .be_pop(be_pop), .be_kill(be_kill), .crd_ret(crd_ret)
    );

    typedef struct packed {
        logic          wr;
        logic [DW-1:0] data;
        logic [TW-1:0] tag;
        logic          pop;
        logic [CW-1:0] ret;
        logic [CW-1:0] cred;
        logic          valid;
        logic [DW-1:0] head;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 16'hA001, 5'd1, 1'b0, 4'd0, 4'd7, 1'b1, 16'hA001},
        '{1'b1, 16'hA002, 5'd2, 1'b0, 4'd0, 4'd6, 1'b1, 16'hA001},
        '{1'b1, 16'hA003, 5'd3, 1'b1, 4'd1, 4'd6, 1'b1, 16'hA002},
        '{1'b0, 16'h0000, 5'd0, 1'b1, 4'd1, 4'd7, 1'b1, 16'hA003},
        '{1'b0, 16'h0000, 5'd0, 1'b1, 4'd1, 4'd8, 1'b0, 16'h0000},
        '{1'b0, 16'h0000, 5'd0, 1'b1, 4'd0, 4'd8, 1'b0, 16'h0000},
        '{1'b1, 16'hB001, 5'd4, 1'b0, 4'd0, 4'd7, 1'b1, 16'hB001},
        '{1'b0, 16'h0000, 5'd0, 1'b1, 4'd1, 4'd8, 1'b0, 16'h0000}
    };

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Drive at the falling edge, check crd_ret before the rising edge,
    // then return at the next falling edge with post-edge state visible.
    task automatic step(input logic wr, input logic [DW-1:0] d, input logic [TW-1:0] t,
                        input logic pop, input logic bk, input logic fk,
                        input logic [TW-1:0] kt, input int exp_ret, input string req);
        fe_valid = wr; fe_data = d; fe_tag = t;
        be_pop = pop; be_kill = bk; fe_kill = fk; fe_kill_tag = kt;
        #1;
        check(req, "crd_ret", int'(crd_ret), exp_ret);
        @(posedge clk);
        @(negedge clk);
        fe_valid = 1'b0; be_pop = 1'b0; be_kill = 1'b0; fe_kill = 1'b0;
    endtask

    task automatic push(input logic [DW-1:0] d, input logic [TW-1:0] t);
        step(1'b1, d, t, 1'b0, 1'b0, 1'b0, '0, 0, "R2");
    endtask

    task automatic pop_expect(input logic [DW-1:0] head, input string req);
        check(req, "be_valid before pop", int'(be_valid), 1);
        check(req, "be_data before pop", int'(be_data), int'(head));
        step(1'b0, '0, '0, 1'b1, 1'b0, 1'b0, '0, 1, "R4");
    endtask

    initial begin
        #400000;
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        check("R1", "fe_credits", int'(fe_credits), 8);
        check("R1", "fe_ready", int'(fe_ready), 1);
        check("R1", "be_valid", int'(be_valid), 0);
        check("R1", "fe_flush", int'(fe_flush), 0);
        check("R1", "crd_ret", int'(crd_ret), 0);
        @(negedge clk);

        // R2/R4 vector walk
        for (int i = 0; i < NV; i++) begin
            step(VEC[i].wr, VEC[i].data, VEC[i].tag, VEC[i].pop, 1'b0, 1'b0, '0,
                 int'(VEC[i].ret), "R4");
            check("R2", "fe_credits", int'(fe_credits), int'(VEC[i].cred));
            check("R2", "be_valid", int'(be_valid), int'(VEC[i].valid));
            if (VEC[i].valid)
                check("R2", "be_data", int'(be_data), int'(VEC[i].head));
        end

        // R3: fill every credit, then a write with none left is dropped
        for (int i = 0; i < 8; i++) push(DW'(16'h0100 + i), TW'(i));
        check("R3", "fe_credits full", int'(fe_credits), 0);
        check("R3", "fe_ready full", int'(fe_ready), 0);
        step(1'b1, 16'hDEAD, 5'd8, 1'b0, 1'b0, 1'b0, '0, 0, "R3");
        check("R3", "fe_credits after drop", int'(fe_credits), 0);
        for (int i = 0; i < 8; i++) pop_expect(DW'(16'h0100 + i), "R3");
        check("R3", "be_valid drained", int'(be_valid), 0);
        check("R4", "fe_credits drained", int'(fe_credits), 8);

        // R6/R7: trim tags 13,14 with boundary 12, then refill behind survivors
        for (int i = 10; i <= 14; i++) push(DW'(16'h0200 + i), TW'(i));
        check("R6", "fe_credits before trim", int'(fe_credits), 3);
        step(1'b0, '0, '0, 1'b0, 1'b0, 1'b1, 5'd12, 2, "R6");
        check("R6", "fe_credits after trim", int'(fe_credits), 5);
        check("R6", "head after trim", int'(be_data), 16'h020A);
        push(16'h0AAA, 5'd13);
        check("R7", "fe_credits after refill", int'(fe_credits), 4);
        pop_expect(16'h020A, "R6");
        pop_expect(16'h020B, "R6");
        pop_expect(16'h020C, "R6");
        pop_expect(16'h0AAA, "R7");
        check("R7", "be_valid drained", int'(be_valid), 0);
        check("R7", "fe_credits drained", int'(fe_credits), 8);

        // R8: wraparound, boundary 31 keeps 30 and 31, drops 0 and 1
        push(16'h0300, 5'd30);
        push(16'h0301, 5'd31);
        push(16'h0302, 5'd0);
        push(16'h0303, 5'd1);
        step(1'b0, '0, '0, 1'b0, 1'b0, 1'b1, 5'd31, 2, "R8");
        check("R8", "fe_credits after wrap trim", int'(fe_credits), 6);
        pop_expect(16'h0300, "R8");
        pop_expect(16'h0301, "R8");
        check("R8", "be_valid drained", int'(be_valid), 0);

        // R10: pop of a surviving head during a trim; write ignored
        push(16'h0404, 5'd4);
        push(16'h0405, 5'd5);
        push(16'h0406, 5'd6);
        step(1'b1, 16'h0BAD, 5'd7, 1'b1, 1'b0, 1'b1, 5'd4, 3, "R10");
        check("R10", "fe_credits", int'(fe_credits), 8);
        check("R10", "be_valid", int'(be_valid), 0);

        // R5: backend flush
        push(16'h0509, 5'd9);
        push(16'h050A, 5'd10);
        push(16'h050B, 5'd11);
        step(1'b1, 16'h0BAD, 5'd12, 1'b0, 1'b1, 1'b0, '0, 3, "R5");
        check("R5", "be_valid", int'(be_valid), 0);
        check("R5", "fe_credits", int'(fe_credits), 8);
        check("R5", "fe_flush", int'(fe_flush), 1);
        step(1'b0, '0, '0, 1'b0, 1'b0, 1'b0, '0, 0, "R5");
        check("R5", "fe_flush one cycle", int'(fe_flush), 0);

        // R9: simultaneous kills, flush wins over trim
        push(16'h0601, 5'd1);
        push(16'h0602, 5'd2);
        step(1'b0, '0, '0, 1'b0, 1'b1, 1'b1, 5'd1, 2, "R9");
        check("R9", "be_valid", int'(be_valid), 0);
        check("R9", "fe_credits", int'(fe_credits), 8);
        check("R9", "fe_flush", int'(fe_flush), 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule